// File: doc/BRIEF.md
# Buffered Host Access Port

This block lets a host processor read and write a 16-bit RAM and a 16-bit register file through a strobed cycle. The host asserts a select and a data strobe together to open a cycle. A memory/register line routes the cycle to one space or the other, and a read/write line gives its direction. Strap inputs can change between cycles. They choose a 16-bit or 8-bit data path, zero-wait or nonzero-wait handshaking, the sense of the direction line, the sense of the byte-select line, which byte of a pair travels first, and whether the address is held from the start of the cycle or followed until the strobe is released.

In 8-bit mode two byte cycles make up one word. A write reaches storage only when the closing byte of the pair arrives. A read fetches the whole word on the opening byte, and the closing byte is served from that fetched copy. The storage itself sits outside the block, behind a single-request access port with a completion pulse. An interrupt output, active low, either gives a fixed-width pulse derived from the clock frequency or holds a level until a clear strobe.

Top module: `hbuf_host_port`

## Requirements
- R1: With the wide strap at 1 (16-bit), a polarity strap of 1 makes a high direction line a read and a low one a write. A polarity strap of 0 reverses this.
- R2: With the wide strap at 0 (8-bit), a high direction line is a read and a low one is a write, whatever the polarity strap.
- R3: In 8-bit mode with the polarity strap at 0, a high byte-select line marks the upper byte and a low one marks the lower byte. A polarity strap of 1 swaps the two meanings.
- R4: In 8-bit mode an order strap of 1 makes the upper byte the opening byte of a pair, and 0 makes the lower byte the opening byte. A write is stored only when the closing byte arrives. A read fetches storage only on the opening byte, and the closing byte comes from the fetched word. In 16-bit mode the order strap has no effect, and every cycle reaches storage.
- R5: Each storage access is a single-cycle request. acc_ram equals the memory/register line, with 1 selecting RAM and 0 selecting registers.
- R6: Nonzero-wait mode (nz strap at 1): ready rises once read data is valid or the write is done. It stays high while the strobe is held and falls in the cycle after the strobe is released.
- R7: Zero-wait mode (nz strap at 0): ready stays low while the strobe is held. It is high in the cycle after release and stays high until the internal transfer completes. Read data is then on host_dout.
- R8: In zero-wait mode with the address strap at 0, the address sampled at cycle start is used. With the strap at 1, the address present at strobe release is used.
- R9: In pulse mode an interrupt event drives irq_n low for exactly CLK_HZ/1000*PULSE_NS/1000000 cycles (62 at the defaults).
- R10: In level mode irq_n stays low after an event until irq_clr is strobed, and returns high in the following cycle.
- R11: After reset, host_ready and acc_req are 0 and irq_n is 1.
- R12: An 8-bit read returns the selected byte on the lower lane of host_dout, with the upper lane zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | Host select |
| host_strb | input | 1 | Data strobe, active high |
| host_mem_nreg | input | 1 | 1 = RAM, 0 = register |
| host_rdwr | input | 1 | Direction line, sense per R1/R2 |
| host_addr | input | AW | Host address |
| host_din | input | DW | Host write data (lower byte in 8-bit mode) |
| host_dout | output | DW | Host read data |
| host_ready | output | 1 | Handshake to host |
| host_byte_hi | input | 1 | Byte-select line, sense per R3 |
| strap_wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| strap_pol | input | 1 | Polarity select |
| strap_msb_first | input | 1 | Byte order select |
| strap_nz_wait | input | 1 | 1 = nonzero wait, 0 = zero wait |
| strap_addr_pass | input | 1 | 0 = address held from start, 1 = address followed to release |
| irq_event | input | 1 | Interrupt trigger pulse |
| irq_level_mode | input | 1 | 1 = level, 0 = pulse |
| irq_clr | input | 1 | Clears a level interrupt |
| irq_n | output | 1 | Interrupt request, active low |
| acc_req | output | 1 | Storage access request pulse |
| acc_we | output | 1 | Access is a write |
| acc_ram | output | 1 | Access targets RAM |
| acc_addr | output | AW | Access address |
| acc_wdata | output | DW | Access write word |
| acc_rdata | input | DW | Access read word |
| acc_done | input | 1 | Access completion pulse |

## Verification
Full-word cycles run under both polarity settings and both order settings. This shows that the direction line is decoded by polarity and that the order strap leaves 16-bit cycles unchanged. Byte pairs run in both order and polarity combinations. Storage is inspected after the opening byte, and the stored word is altered between the two read bytes. These steps show that the commit happens on the closing byte and the fetch on the opening byte. Zero-wait writes change the address at strobe release, which shows the held-address mode apart from the followed-address mode. The interrupt is tried in pulse mode, where the width is counted, and in level mode, where it is held and then cleared.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REL,
        ST_ACCESS,
        ST_HOLD,
        ST_FLUSH
    } cyc_state_e;

    typedef struct packed {
        logic rd;    // cycle is a read
        logic ram;   // RAM space, else register space
        logic acc;   // cycle touches storage
        logic zw;    // zero-wait handshake
    } cyc_cmd_t;

    // Direction decode: polarity only matters on the 16-bit path
    function automatic logic dir_is_read(input logic wide, input logic pol, input logic rdwr);
        if (wide) return (rdwr == pol);
        return rdwr;
    endfunction

    // Byte-select decode: polarity 0 means high line = upper byte
    function automatic logic lane_is_upper(input logic line, input logic pol);
        return line ^ pol;
    endfunction

    // Opening byte fetches on reads; closing byte commits on writes
    function automatic logic needs_access(input logic wide, input logic rd,
                                          input logic upper, input logic upper_first);
        logic opening;
        opening = (upper == upper_first);
        if (wide) return 1'b1;
        return rd ? opening : !opening;
    endfunction

    function automatic int pulse_cycles(input int clk_hz, input int width_ns);
        int c;
        c = (clk_hz / 1000) * width_ns / 1000000;
        return (c < 2) ? 2 : c;
    endfunction

endpackage

// File: rtl/hbuf_cycle_ctl.sv
module hbuf_cycle_ctl
    import hbuf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          strb,
    input  logic          addr_pass,
    input  cyc_cmd_t      live_cmd,
    input  logic [AW-1:0] live_addr,
    input  logic          acc_done,
    output logic          start_o,
    output logic          cap_wdata_o,
    output logic          rd_load_o,
    output logic          ready_o,
    output logic          acc_req_o,
    output logic          acc_we_o,
    output logic          acc_ram_o,
    output logic [AW-1:0] acc_addr_o
);

    cyc_state_e    state;
    cyc_cmd_t      cmd_q;
    logic [AW-1:0] addr_q;
    logic          release_w;

    assign start_o     = (state == ST_IDLE) && sel && strb;
    assign release_w   = (state == ST_WAIT_REL) && !strb;
    assign cap_wdata_o = (start_o && !live_cmd.zw && !live_cmd.rd) || (release_w && !cmd_q.rd);
    assign rd_load_o   = (state == ST_ACCESS) && acc_done && cmd_q.rd;
    assign ready_o     = (state == ST_HOLD) ||
                         (cmd_q.zw && ((state == ST_ACCESS) || (state == ST_FLUSH)));
    assign acc_we_o    = !cmd_q.rd;
    assign acc_ram_o   = cmd_q.ram;
    assign acc_addr_o  = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cmd_q     <= '0;
            addr_q    <= '0;
            acc_req_o <= 1'b0;
        end else begin
            acc_req_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_o) begin
                        cmd_q  <= live_cmd;
                        addr_q <= live_addr;
                        if (live_cmd.zw) begin
                            state <= ST_WAIT_REL;
                        end else if (live_cmd.acc) begin
                            state     <= ST_ACCESS;
                            acc_req_o <= 1'b1;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                ST_WAIT_REL: begin
                    if (!strb) begin
                        if (addr_pass) addr_q <= live_addr;
                        if (cmd_q.acc) begin
                            state     <= ST_ACCESS;
                            acc_req_o <= 1'b1;
                        end else begin
                            state <= ST_FLUSH;
                        end
                    end
                end
                ST_ACCESS: begin
                    if (acc_done) state <= cmd_q.zw ? ST_IDLE : ST_HOLD;
                end
                ST_HOLD: begin
                    if (!strb) state <= ST_IDLE;
                end
                ST_FLUSH: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        acc_req_o |=> !acc_req_o);  // R5
    AST_NZ_READY_HELD: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !cmd_q.zw && strb) |=> ready_o);  // R6
    AST_NZ_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !cmd_q.zw && !strb) |=> !ready_o);  // R6
    AST_ZW_RELEASE_READY: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_WAIT_REL) && !strb) |=> ready_o);  // R7

endmodule

// File: rtl/hbuf_byte_lane.sv
module hbuf_byte_lane #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          live_wide,
    input  logic          live_upper,
    input  logic          cap_wdata,
    input  logic [DW-1:0] din,
    input  logic          rd_load,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] wword,
    output logic [DW-1:0] dout
);

    localparam int BW = DW / 2;

    logic [DW-1:0] hold_q;
    logic [DW-1:0] rword_q;
    logic          upper_q;
    logic          wide_q;
    logic          eff_wide;
    logic          eff_upper;

    assign eff_wide  = start ? live_wide  : wide_q;
    assign eff_upper = start ? live_upper : upper_q;
    assign wword     = hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            rword_q <= '0;
            upper_q <= 1'b0;
            wide_q  <= 1'b1;
        end else begin
            if (start) begin
                upper_q <= live_upper;
                wide_q  <= live_wide;
            end
            if (cap_wdata) begin
                if (eff_wide)       hold_q         <= din;
                else if (eff_upper) hold_q[DW-1:BW] <= din[BW-1:0];
                else                hold_q[BW-1:0]  <= din[BW-1:0];
            end
            if (rd_load) rword_q <= rdata;
        end
    end

    generate
        if (DW == 2 * BW) begin : g_lane_mux
            always_comb begin
                if (wide_q)       dout = rword_q;
                else if (upper_q) dout = {{BW{1'b0}}, rword_q[DW-1:BW]};
                else              dout = {{BW{1'b0}}, rword_q[BW-1:0]};
            end
        end else begin : g_odd
            assign dout = rword_q;
        end
    endgenerate

endmodule

// File: rtl/hbuf_irq_gen.sv
module hbuf_irq_gen
    import hbuf_pkg::*;
#(
    parameter int CLK_HZ   = 125000000,
    parameter int PULSE_NS = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic irq_event,
    input  logic irq_level_mode,
    input  logic irq_clr,
    output logic irq_n
);

    localparam int PULSE_CYC = pulse_cycles(CLK_HZ, PULSE_NS);
    localparam int CW        = $clog2(PULSE_CYC + 1);

    logic          active_q;
    logic          level_q;
    logic [CW-1:0] cnt_q;

    assign irq_n = !active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            level_q  <= 1'b0;
            cnt_q    <= '0;
        end else if (irq_event) begin
            active_q <= 1'b1;
            level_q  <= irq_level_mode;
            cnt_q    <= CW'(PULSE_CYC - 1);
        end else if (active_q) begin
            if (level_q) begin
                if (irq_clr) active_q <= 1'b0;
            end else if (cnt_q == '0) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    AST_PULSE_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
        ($fell(irq_n) && !level_q) |=> !irq_n);  // R9
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && level_q && !irq_clr && !irq_event) |=> !irq_n);  // R10

endmodule

// File: rtl/hbuf_host_port.sv
module hbuf_host_port
    import hbuf_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int CLK_HZ   = 125000000,
    parameter int PULSE_NS = 500
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_sel,
    input  logic          host_strb,
    input  logic          host_mem_nreg,
    input  logic          host_rdwr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_din,
    output logic [DW-1:0] host_dout,
    output logic          host_ready,
    input  logic          host_byte_hi,
    input  logic          strap_wide,
    input  logic          strap_pol,
    input  logic          strap_msb_first,
    input  logic          strap_nz_wait,
    input  logic          strap_addr_pass,
    input  logic          irq_event,
    input  logic          irq_level_mode,
    input  logic          irq_clr,
    output logic          irq_n,
    output logic          acc_req,
    output logic          acc_we,
    output logic          acc_ram,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata,
    input  logic [DW-1:0] acc_rdata,
    input  logic          acc_done
);

    cyc_cmd_t live_cmd;
    logic     live_upper;
    logic     start_w;
    logic     cap_wdata_w;
    logic     rd_load_w;

    always_comb begin
        live_upper   = lane_is_upper(host_byte_hi, strap_pol);
        live_cmd.rd  = dir_is_read(strap_wide, strap_pol, host_rdwr);
        live_cmd.ram = host_mem_nreg;
        live_cmd.zw  = !strap_nz_wait;
        live_cmd.acc = needs_access(strap_wide, live_cmd.rd, live_upper, strap_msb_first);
    end

    hbuf_cycle_ctl #(.AW(AW)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .sel         (host_sel),
        .strb        (host_strb),
        .addr_pass   (strap_addr_pass),
        .live_cmd    (live_cmd),
        .live_addr   (host_addr),
        .acc_done    (acc_done),
        .start_o     (start_w),
        .cap_wdata_o (cap_wdata_w),
        .rd_load_o   (rd_load_w),
        .ready_o     (host_ready),
        .acc_req_o   (acc_req),
        .acc_we_o    (acc_we),
        .acc_ram_o   (acc_ram),
        .acc_addr_o  (acc_addr)
    );

    hbuf_byte_lane #(.DW(DW)) u_lane (
        .clk        (clk),
        .rst        (rst),
        .start      (start_w),
        .live_wide  (strap_wide),
        .live_upper (live_upper),
        .cap_wdata  (cap_wdata_w),
        .din        (host_din),
        .rd_load    (rd_load_w),
        .rdata      (acc_rdata),
        .wword      (acc_wdata),
        .dout       (host_dout)
    );

    hbuf_irq_gen #(.CLK_HZ(CLK_HZ), .PULSE_NS(PULSE_NS)) u_irq (
        .clk            (clk),
        .rst            (rst),
        .irq_event      (irq_event),
        .irq_level_mode (irq_level_mode),
        .irq_clr        (irq_clr),
        .irq_n          (irq_n)
    );

    AST_REQ_ROUTE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !acc_done) |=> ($stable(acc_ram) && $stable(acc_we)));  // R5

endmodule

// File: tb/tb_hbuf_host_port.sv
module tb_hbuf_host_port;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int EXP_PULSE = (125000000 / 1000) * 500 / 1000000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_sel = 0, host_strb = 0, host_mem_nreg = 0, host_rdwr = 0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_din = '0;
    logic [DW-1:0] host_dout;
    logic          host_ready, host_byte_hi = 0;
    logic          strap_wide = 1, strap_pol = 1, strap_msb_first = 1;
    logic          strap_nz_wait = 1, strap_addr_pass = 0;
    logic          irq_event = 0, irq_level_mode = 0, irq_clr = 0, irq_n;
    logic          acc_req, acc_we, acc_ram;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_wdata;
    logic [DW-1:0] acc_rdata;
    logic          acc_done;

    logic [DW-1:0] ram [256];
    logic [DW-1:0] regs [16];
    logic          poke_en = 0;
    logic [AW-1:0] poke_addr = '0;
    logic [DW-1:0] poke_data = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    hbuf_host_port dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_strb(host_strb),
        .host_mem_nreg(host_mem_nreg), .host_rdwr(host_rdwr), .host_addr(host_addr),
        .host_din(host_din), .host_dout(host_dout), .host_ready(host_ready),
        .host_byte_hi(host_byte_hi), .strap_wide(strap_wide), .strap_pol(strap_pol),
        .strap_msb_first(strap_msb_first), .strap_nz_wait(strap_nz_wait),
        .strap_addr_pass(strap_addr_pass), .irq_event(irq_event),
        .irq_level_mode(irq_level_mode), .irq_clr(irq_clr), .irq_n(irq_n),
        .acc_req(acc_req), .acc_we(acc_we), .acc_ram(acc_ram), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_done(acc_done)
    );

    // Storage model: one-cycle response
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) ram[i] <= '0;
            for (int i = 0; i < 16; i++) regs[i] <= '0;
            acc_done  <= 1'b0;
            acc_rdata <= '0;
        end else begin
            acc_done <= 1'b0;
            if (poke_en) ram[poke_addr] <= poke_data;
            if (acc_req) begin
                if (acc_we) begin
                    if (acc_ram) ram[acc_addr] <= acc_wdata;
                    else         regs[acc_addr[3:0]] <= acc_wdata;
                end else begin
                    acc_rdata <= acc_ram ? ram[acc_addr] : regs[acc_addr[3:0]];
                end
                acc_done <= 1'b1;
            end
        end
    end

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        poke_en = 1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 0;
    endtask

    // One host cycle; zw selects zero-wait; a_rel is the address shown at release
    task automatic run_cycle(input logic zw, input logic rdwr, input logic mem,
                             input logic [AW-1:0] a, input logic [AW-1:0] a_rel,
                             input logic [DW-1:0] d, input logic bsel,
                             output logic [DW-1:0] q);
        int guard;
        @(negedge clk);
        strap_nz_wait = !zw;
        host_sel = 1; host_strb = 1; host_rdwr = rdwr; host_mem_nreg = mem;
        host_addr = a; host_din = d; host_byte_hi = bsel;
        if (!zw) begin
            guard = 0;
            do begin @(negedge clk); guard++; end while (!host_ready && guard < 20);
            check("R6 ready rises", {15'd0, host_ready}, 16'd1);
            @(negedge clk);
            check("R6 ready held with strobe", {15'd0, host_ready}, 16'd1);
            q = host_dout;
            host_strb = 0; host_sel = 0;
            @(negedge clk);
            check("R6 ready falls after release", {15'd0, host_ready}, 16'd0);
        end else begin
            @(negedge clk);
            check("R7 ready low under strobe", {15'd0, host_ready}, 16'd0);
            host_strb = 0; host_sel = 0; host_addr = a_rel;
            @(negedge clk);
            check("R7 ready after release", {15'd0, host_ready}, 16'd1);
            guard = 0;
            while (host_ready && guard < 20) begin @(negedge clk); guard++; end
            check("R7 ready falls", {15'd0, host_ready}, 16'd0);
            q = host_dout;
        end
    endtask

    task automatic test_reset();
        check("R11 ready", {15'd0, host_ready}, 16'd0);
        check("R11 acc_req", {15'd0, acc_req}, 16'd0);
        check("R11 irq_n", {15'd0, irq_n}, 16'd1);
    endtask

    task automatic test_wide();
        logic [DW-1:0] q;
        strap_wide = 1; strap_pol = 1; strap_msb_first = 0;
        run_cycle(0, 0, 1, 8'd5, 8'd5, 16'h1234, 0, q);
        check("R5 RAM write routed", ram[5], 16'h1234);
        check("R5 register untouched", regs[5], 16'h0000);
        run_cycle(0, 1, 1, 8'd5, 8'd5, 16'h0, 0, q);
        check("R1 pol1 read", q, 16'h1234);
        strap_pol = 0; strap_msb_first = 1;
        run_cycle(0, 1, 0, 8'd3, 8'd3, 16'hBEEF, 1, q);
        check("R1 pol0 high line writes reg", regs[3], 16'hBEEF);
        check("R4 order ignored in 16-bit", regs[3], 16'hBEEF);
        run_cycle(0, 0, 0, 8'd3, 8'd3, 16'h0, 0, q);
        check("R1 pol0 low line reads", q, 16'hBEEF);
        check("R5 RAM untouched by reg write", ram[3], 16'h0000);
    endtask

    task automatic test_byte_upper_first();
        logic [DW-1:0] q;
        strap_wide = 0; strap_pol = 0; strap_msb_first = 1;
        run_cycle(0, 0, 1, 8'd10, 8'd10, 16'h00AB, 1, q);
        check("R4 no commit on opening byte", ram[10], 16'h0000);
        run_cycle(0, 0, 1, 8'd10, 8'd10, 16'h00CD, 0, q);
        check("R4 commit on closing byte", ram[10], 16'hABCD);
        run_cycle(0, 1, 1, 8'd10, 8'd10, 16'h0, 1, q);
        check("R12 upper byte on low lane", q, 16'h00AB);
        poke(8'd10, 16'h1111);
        run_cycle(0, 1, 1, 8'd10, 8'd10, 16'h0, 0, q);
        check("R4 closing byte from fetched word", q, 16'h00CD);
        run_cycle(0, 1, 1, 8'd10, 8'd10, 16'h0, 1, q);
        check("R4 opening byte refetches", q, 16'h0011);
    endtask

    task automatic test_byte_lower_first();
        logic [DW-1:0] q;
        strap_wide = 0; strap_pol = 1; strap_msb_first = 0;
        run_cycle(0, 0, 1, 8'd20, 8'd20, 16'h0077, 1, q);
        check("R2 low line writes with pol1", ram[20], 16'h0000);
        run_cycle(0, 0, 1, 8'd20, 8'd20, 16'h0066, 0, q);
        check("R3 pol1 high line is lower byte", ram[20], 16'h6677);
        run_cycle(0, 1, 1, 8'd20, 8'd20, 16'h0, 1, q);
        check("R2 high line reads with pol1", q, 16'h0077);
    endtask

    task automatic test_zero_wait();
        logic [DW-1:0] q;
        strap_wide = 1; strap_pol = 1; strap_addr_pass = 0;
        run_cycle(1, 0, 1, 8'd30, 8'd31, 16'h5A5A, 0, q);
        check("R8 held address used", ram[30], 16'h5A5A);
        check("R8 release address unused", ram[31], 16'h0000);
        strap_addr_pass = 1;
        run_cycle(1, 0, 1, 8'd40, 8'd41, 16'h0F0F, 0, q);
        check("R8 release address used", ram[41], 16'h0F0F);
        check("R8 start address unused", ram[40], 16'h0000);
        strap_addr_pass = 0;
        run_cycle(1, 1, 1, 8'd30, 8'd30, 16'h0, 0, q);
        check("R7 zero-wait read data", q, 16'h5A5A);
    endtask

    task automatic test_irq_pulse();
        int low;
        irq_level_mode = 0;
        @(negedge clk); irq_event = 1;
        @(negedge clk); irq_event = 0;
        low = 0;
        while (!irq_n && low < 300) begin low++; @(negedge clk); end
        check("R9 pulse width", 16'(low), 16'(EXP_PULSE));
    endtask

    task automatic test_irq_level();
        irq_level_mode = 1;
        @(negedge clk); irq_event = 1;
        @(negedge clk); irq_event = 0;
        repeat (100) @(negedge clk);
        check("R10 level held", {15'd0, irq_n}, 16'd0);
        irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        check("R10 cleared", {15'd0, irq_n}, 16'd1);
    endtask

    bit finished = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        test_reset();
        test_wide();
        test_byte_upper_first();
        test_byte_lower_first();
        test_zero_wait();
        test_irq_pulse();
        test_irq_level();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule